// File: doc/BRIEF.md
# Open-Row DRAM Read Sequencer

This block sits on the controller side of a DRAM array and turns single-word read requests into the phases the array needs. An incoming address is split into a row half (upper bits) and a column half (lower bits). Both halves are placed, one after the other, on a single shared address bus. A row strobe qualifies the row half and a column strobe qualifies the column half. The array senses the whole row when it is activated, and each column strobe picks one word out of that latched row.

The sequencer remembers which row is open. When a read targets the open row, the sequencer issues only a column phase. When a read targets any other row, the sequencer first issues one precharge pulse, which closes the open row, turns off sensing and precharges the bit-lines. It then waits the precharge-to-activate delay, activates the new row, waits the activate-to-column delay, and issues the column phase. After reset no row is open, so the first read always takes the full path.

Requests use a valid/ready handshake. A request is taken in the cycle where `rd_req_valid` and `rd_req_ready` are both high. Ready is high only while the sequencer is idle, so the requester is held off for the whole access. While ready is low the address may change freely and has no effect. Read data returns as a one-cycle `rd_rsp_valid` pulse. This output has no back-pressure, and the receiver must take the word in that cycle.

Top module: `dram_row_seq`

## Requirements
- R1: After reset `rd_req_ready` is 1, and `arr_pre`, `arr_row_stb`, `arr_col_stb` and `rd_rsp_valid` are 0. No row counts as open, so the first accepted read performs a precharge and an activation.
- R2: Address fields are split as follows:
  - The row is `rd_req_addr[ROW_W+COL_W-1:COL_W]`. It is driven on `arr_addr` (zero-extended) in the cycle where `arr_row_stb` is high.
  - The column is `rd_req_addr[COL_W-1:0]`. It is driven on `arr_addr` (zero-extended) in the cycle where `arr_col_stb` is high.
- R3: A read to a row other than the open one, or the first read after reset, produces exactly one `arr_pre` pulse, then one `arr_row_stb` pulse, then one `arr_col_stb` pulse. The row strobe only occurs while no row is open.
- R4: A read to the open row produces no `arr_pre` and no `arr_row_stb` pulse, and exactly one `arr_col_stb` pulse. A column strobe only occurs while a row is open.
- R5: The `arr_row_stb` pulse comes exactly T_PRE cycles after the `arr_pre` pulse.
- R6: On a full-path read, the `arr_col_stb` pulse comes exactly T_ACT cycles after the `arr_row_stb` pulse.
- R7: `rd_rsp_valid` is a single-cycle pulse, high exactly T_CL+1 cycles after the `arr_col_stb` cycle. In that cycle `rd_rsp_data` holds `arr_rdata` as sampled T_CL cycles after the column strobe, which is the word at the requested row and column.
- R8: `rd_req_ready` is high only when idle. It goes low in the cycle after a request is accepted and stays low until that read's response pulse.
- R9: At most one of `arr_pre`, `arr_row_stb` and `arr_col_stb` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req_valid | input | 1 | Read request present |
| rd_req_ready | output | 1 | Sequencer can accept a request |
| rd_req_addr | input | ROW_W+COL_W | Read address, row in upper bits |
| rd_rsp_valid | output | 1 | One-cycle pulse: read data present |
| rd_rsp_data | output | DATA_W | Read data word |
| arr_pre | output | 1 | Close row and precharge pulse |
| arr_row_stb | output | 1 | Row strobe, qualifies row on arr_addr |
| arr_col_stb | output | 1 | Column strobe, qualifies column on arr_addr |
| arr_addr | output | max(ROW_W,COL_W) | Shared multiplexed address bus |
| arr_rdata | input | DATA_W | Word selected by the array |

## Verification
The bench goes after the following corner cases:
- **First read after reset.** A design that assumed a stale open row would skip the activation and return a word from the wrong row.
- **Same-row streaks, including the top column.** A design that re-precharged here would show extra strobes. A design with a bad column field would return wrong data.
- **Row changes.** A design that activated without closing, or that miscounted the delays, would put the row and column strobes at the wrong distance.
- **Requests at the end of a response.** These expose a ready signal that reopens too early or a response pulse that lasts more than one cycle.

// File: rtl/drs_pkg.sv
package drs_pkg;
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_PRE  = 3'd1,
    S_ACT  = 3'd2,
    S_COL  = 3'd3,
    S_DATA = 3'd4
  } drs_state_e;
endpackage

// File: rtl/drs_delay_cnt.sv
module drs_delay_cnt #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] TOP = {CW{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             count <= '0;
    else if (restart)       count <= '0;
    else if (count != TOP)  count <= count + 1'b1;
  end
endmodule

// File: rtl/drs_row_track.sv
module drs_row_track #(
  parameter int ROW_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             close_row,
  input  logic             open_row,
  input  logic [ROW_W-1:0] open_id,
  input  logic [ROW_W-1:0] probe_id,
  output logic             is_open,
  output logic             probe_hit
);
  logic [ROW_W-1:0] cur_row;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      is_open <= 1'b0;
      cur_row <= '0;
    end else if (close_row) begin
      is_open <= 1'b0;
    end else if (open_row) begin
      is_open <= 1'b1;
      cur_row <= open_id;
    end
  end

  assign probe_hit = is_open && (cur_row == probe_id);

  // R3: a row strobe and a precharge never coincide, so a close always finishes before an open
  a_r3_no_open_during_close: assert property (@(posedge clk) disable iff (!rst_n)
    close_row |-> !open_row);
endmodule

// File: rtl/dram_row_seq.sv
module dram_row_seq
  import drs_pkg::*;
#(
  parameter int ROW_W  = 4,
  parameter int COL_W  = 4,
  parameter int DATA_W = 16,
  parameter int T_PRE  = 2,
  parameter int T_ACT  = 3,
  parameter int T_CL   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_req_valid,
  output logic                     rd_req_ready,
  input  logic [ROW_W+COL_W-1:0]   rd_req_addr,
  output logic                     rd_rsp_valid,
  output logic [DATA_W-1:0]        rd_rsp_data,
  output logic                     arr_pre,
  output logic                     arr_row_stb,
  output logic                     arr_col_stb,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] arr_addr,
  input  logic [DATA_W-1:0]        arr_rdata
);
  localparam int AW    = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int TM1   = (T_PRE > T_ACT) ? T_PRE : T_ACT;
  localparam int TMAX  = (TM1 > T_CL) ? TM1 : T_CL;
  localparam int CW    = $clog2(TMAX + 2);
  localparam logic [CW-1:0] PRE_END  = CW'(T_PRE - 1);
  localparam logic [CW-1:0] ACT_END  = CW'(T_ACT - 1);
  localparam logic [CW-1:0] DATA_END = CW'(T_CL - 1);

  drs_state_e        state, state_nx;
  logic [CW-1:0]     phase_cnt;
  logic [ROW_W-1:0]  tgt_row;
  logic [COL_W-1:0]  tgt_col;
  logic              row_is_open, row_hit;
  logic              take_req;

  wire [ROW_W-1:0] in_row = rd_req_addr[ROW_W+COL_W-1:COL_W];
  wire [COL_W-1:0] in_col = rd_req_addr[COL_W-1:0];

  assign rd_req_ready = (state == S_IDLE);
  assign take_req     = rd_req_valid && rd_req_ready;

  drs_row_track #(.ROW_W(ROW_W)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .close_row (arr_pre),
    .open_row  (arr_row_stb),
    .open_id   (tgt_row),
    .probe_id  (in_row),
    .is_open   (row_is_open),
    .probe_hit (row_hit)
  );

  drs_delay_cnt #(.CW(CW)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (state_nx != state),
    .count   (phase_cnt)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      S_IDLE: if (take_req) state_nx = row_hit ? S_COL : S_PRE;
      S_PRE:  if (phase_cnt == PRE_END) state_nx = S_ACT;
      S_ACT:  if (phase_cnt == ACT_END) state_nx = S_COL;
      S_COL:  state_nx = S_DATA;
      S_DATA: if (phase_cnt == DATA_END) state_nx = S_IDLE;
      default: state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      tgt_row      <= '0;
      tgt_col      <= '0;
      rd_rsp_valid <= 1'b0;
      rd_rsp_data  <= '0;
    end else begin
      state        <= state_nx;
      rd_rsp_valid <= 1'b0;
      if (take_req) begin
        tgt_row <= in_row;
        tgt_col <= in_col;
      end
      if (state == S_DATA && phase_cnt == DATA_END) begin
        rd_rsp_valid <= 1'b1;
        rd_rsp_data  <= arr_rdata;
      end
    end
  end

  assign arr_pre     = (state == S_PRE) && (phase_cnt == '0);
  assign arr_row_stb = (state == S_ACT) && (phase_cnt == '0);
  assign arr_col_stb = (state == S_COL);
  assign arr_addr    = (state == S_ACT) ? AW'(tgt_row) : AW'(tgt_col);

  // Checker counter: cycles elapsed since the last precharge pulse
  localparam int SW = $clog2(T_PRE + 2) + 1;
  localparam logic [SW-1:0] S_TOP = {SW{1'b1}};
  logic [SW-1:0] since_pre;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   since_pre <= '0;
    else if (arr_pre)                             since_pre <= SW'(1);
    else if (since_pre != '0 && since_pre != S_TOP) since_pre <= since_pre + 1'b1;
  end

  // R9
  a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arr_pre, arr_row_stb, arr_col_stb}));
  // R3
  a_r3_act_only_when_closed: assert property (@(posedge clk) disable iff (!rst_n)
    arr_row_stb |-> !row_is_open);
  // R4
  a_r4_col_needs_open_row: assert property (@(posedge clk) disable iff (!rst_n)
    arr_col_stb |-> row_is_open);
  // R5
  a_r5_pre_to_act: assert property (@(posedge clk) disable iff (!rst_n)
    arr_row_stb |-> (since_pre == SW'(T_PRE)));
  // R7
  a_r7_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rsp_valid |=> !rd_rsp_valid);
  // R8
  a_r8_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    take_req |=> !rd_req_ready);
endmodule

// File: tb/dram_row_seq_test.sv
module dram_row_seq_test;
  localparam int ROW_W = 4, COL_W = 4, DATA_W = 16;
  localparam int T_PRE = 2, T_ACT = 3, T_CL = 2;
  localparam int AW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rd_req_valid = 1'b0;
  logic rd_req_ready;
  logic [ROW_W+COL_W-1:0] rd_req_addr = '0;
  logic rd_rsp_valid;
  logic [DATA_W-1:0] rd_rsp_data;
  logic arr_pre, arr_row_stb, arr_col_stb;
  logic [AW-1:0] arr_addr;
  logic [DATA_W-1:0] arr_rdata;

  always #5 clk = ~clk;

  dram_row_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
                 .T_PRE(T_PRE), .T_ACT(T_ACT), .T_CL(T_CL)) uut (
    .clk(clk), .rst_n(rst_n), .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_addr(rd_req_addr), .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .arr_pre(arr_pre), .arr_row_stb(arr_row_stb), .arr_col_stb(arr_col_stb),
    .arr_addr(arr_addr), .arr_rdata(arr_rdata));

  function automatic logic [DATA_W-1:0] cell_word(input logic [ROW_W-1:0] r, input logic [COL_W-1:0] c);
    return {4'h5, r, c, r ^ c};
  endfunction

  // Synchronous array model: row latched on row strobe, word picked on column strobe
  logic [ROW_W-1:0] m_row = '0;
  logic [DATA_W-1:0] m_rd = '0;
  always @(posedge clk) begin
    if (arr_row_stb) m_row <= arr_addr[ROW_W-1:0];
    if (arr_col_stb) m_rd <= cell_word(m_row, arr_addr[COL_W-1:0]);
  end
  assign arr_rdata = m_rd;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  int n_pre = 0, n_ras = 0, n_cas = 0, n_rsp = 0, n_overlap = 0;
  int t_pre = 0, t_ras = 0, t_cas = 0, t_rsp = 0;
  int a_ras = 0, a_cas = 0;
  logic [DATA_W-1:0] d_rsp = '0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (int'(arr_pre) + int'(arr_row_stb) + int'(arr_col_stb) > 1) n_overlap++;
      if (arr_pre)     begin n_pre++; t_pre = cyc; end
      if (arr_row_stb) begin n_ras++; t_ras = cyc; a_ras = int'(arr_addr); end
      if (arr_col_stb) begin n_cas++; t_cas = cyc; a_cas = int'(arr_addr); end
      if (rd_rsp_valid) begin n_rsp++; t_rsp = cyc; d_rsp = rd_rsp_data; end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  bit b_open = 1'b0;
  logic [ROW_W-1:0] b_row = '0;

  task automatic do_read(input logic [ROW_W-1:0] r, input logic [COL_W-1:0] c);
    int p0, r0, c0, s0, guard;
    bit hit;
    hit = b_open && (r == b_row);
    @(negedge clk); #1;
    while (!rd_req_ready) begin @(negedge clk); #1; end
    p0 = n_pre; r0 = n_ras; c0 = n_cas; s0 = n_rsp;
    rd_req_valid = 1'b1;
    rd_req_addr  = {r, c};
    @(negedge clk); #1;
    rd_req_valid = 1'b0;
    rd_req_addr  = ~{r, c};  // R8: address while busy must have no effect
    chk(rd_req_ready == 1'b0, "R8", "ready after accept", int'(rd_req_ready), 0);
    guard = 0;
    while (n_rsp == s0 && guard < 200) begin @(negedge clk); #1; guard++; end
    chk(n_rsp == s0 + 1, "R7", "response count", n_rsp - s0, 1);
    chk(d_rsp == cell_word(r, c), "R7", "read data", int'(d_rsp), int'(cell_word(r, c)));
    chk(t_rsp - t_cas == T_CL + 1, "R7", "col to data cycles", t_rsp - t_cas, T_CL + 1);
    chk(a_cas == int'(c), "R2", "column on bus", a_cas, int'(c));
    chk(rd_req_ready == 1'b1, "R8", "ready at response", int'(rd_req_ready), 1);
    if (hit) begin
      chk(n_pre == p0 && n_ras == r0, "R4", "pre+act on row hit", (n_pre - p0) + (n_ras - r0), 0);
      chk(n_cas == c0 + 1, "R4", "col strobes on hit", n_cas - c0, 1);
    end else begin
      chk(n_pre == p0 + 1, "R3", "precharges on miss", n_pre - p0, 1);
      chk(n_ras == r0 + 1, "R3", "activates on miss", n_ras - r0, 1);
      chk(n_cas == c0 + 1, "R3", "col strobes on miss", n_cas - c0, 1);
      chk(t_ras - t_pre == T_PRE, "R5", "pre to act cycles", t_ras - t_pre, T_PRE);
      chk(t_cas - t_ras == T_ACT, "R6", "act to col cycles", t_cas - t_ras, T_ACT);
      chk(a_ras == int'(r), "R2", "row on bus", a_ras, int'(r));
    end
    b_open = 1'b1;
    b_row  = r;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    logic [ROW_W-1:0] rr;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk(rd_req_ready == 1'b1, "R1", "ready after reset", int'(rd_req_ready), 1);
    chk({arr_pre, arr_row_stb, arr_col_stb, rd_rsp_valid} == 4'b0, "R1", "strobes after reset",
        int'({arr_pre, arr_row_stb, arr_col_stb, rd_rsp_valid}), 0);
    // R1: first read must take the full path even to row 0
    do_read(4'd0, 4'd0);
    do_read(4'd0, 4'd15);   // R4 hit, top column
    do_read(4'd0, 4'd7);
    do_read(4'd15, 4'd15);  // R3 miss, top row
    do_read(4'd3, 4'd1);
    do_read(4'd3, 4'd1);    // repeat same word
    rr = 4'd3;
    for (int i = 0; i < 60; i++) begin
      if ($urandom % 3 == 0) rr = ROW_W'($urandom);
      do_read(rr, COL_W'($urandom));
    end
    chk(n_overlap == 0, "R9", "overlapping strobe cycles", n_overlap, 0);
    finish_run();
  end
endmodule